// File: doc/BRIEF.md
# Bit-Sliced Ripple-Carry ALU

This block is a 32-bit arithmetic and logic unit made of identical one-bit slices. Each slice holds a full adder, an AND gate, an OR gate and a four-way output mux. Every slice shares the same operation controls. The carry passes from each slice to the one above it, so a sum settles bit by bit from the least significant end. A single negate control inverts B in every slice and also supplies the carry into bit 0. With that one line the same adder computes A − B in two's complement.

Set-on-less-than needs no comparator. The raw adder sum bit of the top slice is routed back into the spare fourth mux input of bit 0, and that input is tied to 0 in every other slice. The resulting word is 1 exactly when the sign of A − B is set. No overflow correction is applied.

The slice network is combinational. The result and the zero, overflow and carry flags are captured in one output register stage, so they appear one clock after the operands and controls are presented.

Top module: `rca_alu`

## Requirements
- R1: While `rst_ni` is low, all outputs are 0. Outside reset, the outputs show the operation applied to the inputs that were present at the previous rising clock edge.
- R2: With `sel_i` = 00 and `neg_i` = 0, `res_o` is the bitwise AND of A and B.
- R3: With `sel_i` = 01 and `neg_i` = 0, `res_o` is the bitwise OR of A and B.
- R4: With `sel_i` = 10 and `neg_i` = 0, `res_o` is A + B modulo 2^32, and `cout_o` is the carry out of bit 31.
- R5: With `sel_i` = 10 and `neg_i` = 1, `res_o` is A + ~B + 1 = A − B modulo 2^32, and `cout_o` is the carry out of that sum (1 when A ≥ B unsigned).
- R6: With `sel_i` = 11 and `neg_i` = 1, bits 31..1 of `res_o` are 0. Bit 0 equals bit 31 of the wrapped difference A − B. For example, A = 0x80000000 and B = 1 give 0, because the subtraction overflows and no correction is applied.
- R7: `neg_i` inverts B in every slice for every select. With `neg_i` = 1, select 00 yields A AND ~B and select 01 yields A OR ~B.
- R8: `zero_o` is 1 exactly when all 32 bits of `res_o` are 0.
- R9: `ovf_o` is 1 when the carry into bit 31 differs from the carry out of bit 31. This is the same as: the two adder operands A and (neg ? ~B : B) have equal sign bits, and the sum's sign bit differs from them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opa_i | input | 32 | Operand A |
| opb_i | input | 32 | Operand B |
| sel_i | input | 2 | Slice output select: 00 AND, 01 OR, 10 sum, 11 less |
| neg_i | input | 1 | Inverts B and sets the carry into bit 0 |
| res_o | output | 32 | Registered result |
| zero_o | output | 1 | Registered all-zero flag of the result |
| ovf_o | output | 1 | Registered carry-in/carry-out mismatch of bit 31 |
| cout_o | output | 1 | Registered carry out of bit 31 |

## Verification
The hardest case to reach from the ports is a set-on-less-than whose subtraction overflows, so that the feedback from the top slice reports the wrong order. Random operands seldom land there. The stimulus therefore crosses a fixed set of extreme operands (0, all-ones, 0x80000000, 0x7FFFFFFF, 1 and a mixed pattern) with every control code, which places the top-slice carry chain on both sides of the sign boundary. Equal operands under subtraction drive the zero flag. A long random run follows to exercise full-length carry ripples.

// File: rtl/rca_alu_pkg.sv
package rca_alu_pkg;

    // Slice output select; the code values are decoded by every slice mux
    typedef enum logic [1:0] {
        FN_AND  = 2'b00,
        FN_OR   = 2'b01,
        FN_SUM  = 2'b10,
        FN_LESS = 2'b11
    } fn_sel_e;

endpackage

// File: rtl/rca_slice.sv
module rca_slice
    import rca_alu_pkg::*;
(
    input  logic    a_i,
    input  logic    b_i,
    input  logic    neg_i,
    input  logic    cin_i,
    input  logic    less_i,
    input  fn_sel_e sel_i,
    output logic    res_o,
    output logic    cout_o,
    output logic    set_o
);

    logic b_eff;
    logic half_sum;
    logic full_sum;

    always_comb begin
        b_eff    = b_i ^ neg_i;
        half_sum = a_i ^ b_eff;
        full_sum = half_sum ^ cin_i;
        cout_o   = (a_i & b_eff) | (cin_i & half_sum);
        // raw adder output, independent of the mux
        set_o    = full_sum;
        unique case (sel_i)
            FN_AND:  res_o = a_i & b_eff;
            FN_OR:   res_o = a_i | b_eff;
            FN_SUM:  res_o = full_sum;
            FN_LESS: res_o = less_i;
            default: res_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/rca_chain.sv
module rca_chain
    import rca_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  fn_sel_e      sel_i,
    input  logic         neg_i,
    output logic [W-1:0] res_o,
    output logic         msb_cin_o,
    output logic         msb_cout_o
);

    localparam int TOP = W - 1;

    logic [W:0]   carry;
    logic [W-1:0] less_vec;
    logic [W-1:0] set_vec;
    logic         unused_set_bits;

    assign carry[0] = neg_i;

    generate
        for (genvar i = 0; i < W; i++) begin : g_slice
            if (i == 0) begin : g_lsb
                assign less_vec[i] = set_vec[TOP];
            end else begin : g_upper
                assign less_vec[i] = 1'b0;
            end

            rca_slice u_slice (
                .a_i    (opa_i[i]),
                .b_i    (opb_i[i]),
                .neg_i  (neg_i),
                .cin_i  (carry[i]),
                .less_i (less_vec[i]),
                .sel_i  (sel_i),
                .res_o  (res_o[i]),
                .cout_o (carry[i+1]),
                .set_o  (set_vec[i])
            );
        end
    endgenerate

    assign unused_set_bits = ^set_vec[TOP-1:0];
    assign msb_cin_o       = carry[TOP];
    assign msb_cout_o      = carry[W];

endmodule

// File: rtl/rca_flags.sv
module rca_flags #(
    parameter int W = 32
) (
    input  logic [W-1:0] res_i,
    input  logic         msb_cin_i,
    input  logic         msb_cout_i,
    output logic         zero_o,
    output logic         ovf_o
);

    always_comb begin
        zero_o = ~|res_i;
        ovf_o  = msb_cin_i ^ msb_cout_i;
    end

endmodule

// File: rtl/rca_alu.sv
module rca_alu
    import rca_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic [1:0]   sel_i,
    input  logic         neg_i,
    output logic [W-1:0] res_o,
    output logic         zero_o,
    output logic         ovf_o,
    output logic         cout_o
);

    typedef struct packed {
        logic [W-1:0] res;
        logic         zero;
        logic         ovf;
        logic         cout;
    } out_t;

    out_t         out_d;
    out_t         out_q;
    logic [W-1:0] chain_res;
    logic         msb_cin;
    logic         msb_cout;
    logic         flag_zero;
    logic         flag_ovf;

    rca_chain #(.W(W)) u_chain (
        .opa_i      (opa_i),
        .opb_i      (opb_i),
        .sel_i      (fn_sel_e'(sel_i)),
        .neg_i      (neg_i),
        .res_o      (chain_res),
        .msb_cin_o  (msb_cin),
        .msb_cout_o (msb_cout)
    );

    rca_flags #(.W(W)) u_flags (
        .res_i      (chain_res),
        .msb_cin_i  (msb_cin),
        .msb_cout_i (msb_cout),
        .zero_o     (flag_zero),
        .ovf_o      (flag_ovf)
    );

    always_comb begin
        out_d      = out_q;
        out_d.res  = chain_res;
        out_d.zero = flag_zero;
        out_d.ovf  = flag_ovf;
        out_d.cout = msb_cout;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign res_o  = out_q.res;
    assign zero_o = out_q.zero;
    assign ovf_o  = out_q.ovf;
    assign cout_o = out_q.cout;

endmodule

// File: rtl/rca_alu_chk.sv
module rca_alu_chk #(
    parameter int W = 32
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic [W-1:0] opa_i,
    input logic [W-1:0] opb_i,
    input logic [1:0]   sel_i,
    input logic         neg_i,
    input logic [W-1:0] res_o,
    input logic         zero_o,
    input logic         ovf_o,
    input logic         cout_o
);

    logic primed_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) primed_q <= 1'b0;
        else         primed_q <= 1'b1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk_i)
        !rst_ni |-> (res_o == '0 && !zero_o && !ovf_o && !cout_o)); // R1

    AST_AND_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (primed_q && $past(sel_i == 2'b00 && !neg_i)) |-> res_o == $past(opa_i & opb_i)); // R2

    AST_OR_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (primed_q && $past(sel_i == 2'b01 && !neg_i)) |-> res_o == $past(opa_i | opb_i)); // R3

    AST_ADD_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (primed_q && $past(sel_i == 2'b10 && !neg_i)) |-> res_o == $past(opa_i + opb_i)); // R4

    AST_SUB_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (primed_q && $past(sel_i == 2'b10 && neg_i)) |-> res_o == $past(opa_i - opb_i)); // R5

    AST_SLT_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (primed_q && $past(sel_i == 2'b11)) |-> $countones(res_o[W-1:1]) == 0); // R6

    AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        primed_q |-> zero_o == (res_o == '0)); // R8

    AST_ADD_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (primed_q && $past(sel_i == 2'b10 && !neg_i)) |->
        ovf_o == ($past(opa_i[W-1] == opb_i[W-1]) && (res_o[W-1] != $past(opa_i[W-1])))); // R9

endmodule

bind rca_alu rca_alu_chk #(.W(W)) chk_i (.*);

// File: tb/rca_alu_tb_top.sv
module rca_alu_tb_top;

    localparam int W = 32;

    typedef struct {
        logic [W-1:0] res;
        logic         zero;
        logic         ovf;
        logic         cout;
        string        tag;
    } exp_t;

    logic         clk_i = 1'b0;
    logic         rst_ni;
    logic [W-1:0] opa_i;
    logic [W-1:0] opb_i;
    logic [1:0]   sel_i;
    logic         neg_i;
    logic [W-1:0] res_o;
    logic         zero_o;
    logic         ovf_o;
    logic         cout_o;

    exp_t sb_q[$];
    int   n_vec = 0;
    int   n_bad = 0;

    always #2 clk_i = ~clk_i;

    rca_alu #(.W(W)) dut_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .opa_i  (opa_i),
        .opb_i  (opb_i),
        .sel_i  (sel_i),
        .neg_i  (neg_i),
        .res_o  (res_o),
        .zero_o (zero_o),
        .ovf_o  (ovf_o),
        .cout_o (cout_o)
    );

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [1:0] sel, input logic neg);
        exp_t         e;
        logic [W-1:0] bx;
        logic [W:0]   s;
        @(negedge clk_i);
        opa_i = a;
        opb_i = b;
        sel_i = sel;
        neg_i = neg;
        bx = neg ? ~b : b;
        s  = {1'b0, a} + {1'b0, bx} + (W+1)'(neg);
        case (sel)
            2'b00:   e.res = a & bx;
            2'b01:   e.res = a | bx;
            2'b10:   e.res = s[W-1:0];
            default: e.res = {{(W-1){1'b0}}, s[W-1]};
        endcase
        e.zero = (e.res == '0);
        e.ovf  = (a[W-1] == bx[W-1]) && (s[W-1] != a[W-1]);
        e.cout = s[W];
        case (sel)
            2'b00:   e.tag = neg ? "R7" : "R2";
            2'b01:   e.tag = neg ? "R7" : "R3";
            2'b10:   e.tag = neg ? "R5" : "R4";
            default: e.tag = "R6";
        endcase
        sb_q.push_back(e);
    endtask

    // monitor: results appear one edge after the driving negedge
    initial begin
        forever begin
            @(posedge clk_i);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_vec++;
                if (res_o !== e.res) begin
                    n_bad++;
                    $display("FAIL %s result: actual=%h expected=%h", e.tag, res_o, e.res);
                end
                if (zero_o !== e.zero) begin
                    n_bad++;
                    $display("FAIL R8 zero: actual=%b expected=%b", zero_o, e.zero);
                end
                if (ovf_o !== e.ovf) begin
                    n_bad++;
                    $display("FAIL R9 overflow: actual=%b expected=%b", ovf_o, e.ovf);
                end
                if (cout_o !== e.cout) begin
                    n_bad++;
                    $display("FAIL R4 carry out: actual=%b expected=%b", cout_o, e.cout);
                end
            end
        end
    end

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [W-1:0] corners [6];
        logic [1:0]   code_sel [7];
        logic         code_neg [7];
        corners  = '{32'h0, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'h1, 32'hDEAD_BEEF};
        code_sel = '{2'b00, 2'b01, 2'b10, 2'b10, 2'b11, 2'b00, 2'b01};
        code_neg = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};

        // R1: outputs held clear during reset with busy inputs
        rst_ni = 1'b0;
        opa_i  = 32'hFFFF_FFFF;
        opb_i  = 32'h1;
        sel_i  = 2'b10;
        neg_i  = 1'b0;
        repeat (3) @(posedge clk_i);
        #1;
        n_vec++;
        if (res_o !== '0 || zero_o !== 1'b0 || ovf_o !== 1'b0 || cout_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: actual=%h/%b%b%b expected=0/000", res_o, zero_o, ovf_o, cout_o);
        end
        @(negedge clk_i);
        rst_ni = 1'b1;

        // R6: overflowing subtraction gives the uncorrected answer 0
        apply(32'h8000_0000, 32'h1, 2'b11, 1'b1);
        // R6: ordinary signed compare, -1 < 1
        apply(32'hFFFF_FFFF, 32'h1, 2'b11, 1'b1);
        // R8: equal operands under subtraction
        apply(32'h1234_5678, 32'h1234_5678, 2'b10, 1'b1);
        // R4, R9: positive overflow on add
        apply(32'h7FFF_FFFF, 32'h1, 2'b10, 1'b0);

        for (int c = 0; c < 7; c++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    apply(corners[i], corners[j], code_sel[c], code_neg[c]);

        for (int c = 0; c < 7; c++)
            for (int k = 0; k < 150; k++)
                apply($urandom(), $urandom(), code_sel[c], code_neg[c]);

        repeat (4) @(posedge clk_i);
        #1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule